// File: doc/BRIEF.md
# Fractional Clock-Enable Divider

This block runs on a free-running clock and produces an enable stream whose average rate is n/m of the clock rate, for example 12 enables in every 13 cycles. Software never supplies n and m directly. It writes two step fields, and a residue accumulator moves by these steps on every cycle. The add step equals m - n. The subtract step is stored as an unsigned W-bit field that the block reads as a negative number. Its magnitude is n = 2^W minus the field value.

Two control bits complete the configuration. A run bit starts the divider; clearing it stops the divider and returns the accumulator to zero. A stretch bit turns the output from single-cycle pulses into a level that stays high for roughly the first half of each output period. The field width is a parameter (8 by default, 13 for wide configurations). The block does not compute the step values from n and m, and it does not select or switch clocks.

Top module: `frac_en_div`

## Requirements
- R1: During and after reset the output is 0 and the residue is 0, so the first running cycle behaves as a start from zero.
- R2: With the subtract field F, n = 2^W - F and m = add field + n. In pulse mode, with the configuration held, every m consecutive output cycles contain exactly n high cycles. Each high cycle is a single-cycle pulse unless the next cycle is also a pulse.
- R3: The residue update is decided at each clock edge while run is high. If the residue is below n, the add step is added and the output is 1 in the following cycle (pulse mode). Otherwise n is subtracted and the output is 0. The output is registered, one cycle after the decision.
- R4: While run is low, the residue is held at zero and the output is 0 from the next edge on, whatever the step fields and stretch bit hold.
- R5: The first edge with run high after run was low always yields a pulse in pulse mode.
- R6: An add field of 0 (m = n) makes the output high in every running cycle.
- R7: In stretch mode the output is 1 exactly when twice the updated residue is at least m. When 2n <= m, every m consecutive cycles contain exactly n rising edges.
- R8: Multiplying both n and the add step by the same power of two gives the same output sequence.
- R9: A subtract field of 0 means n = 2^W.
- R10: Step fields and the stretch bit may change while running. The new values apply from the next edge, and the residue is kept, not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMadd | input | FieldW | Add step, equal to m - n |
| cfgMsub | input | FieldW | Subtract field F, read as the negative step -(2^W - F) |
| cfgRun | input | 1 | Enables the divider; low clears the residue |
| cfgStretch | input | 1 | 1 selects the half-period level, 0 selects single-cycle pulses |
| divOut | output | 1 | Divided enable or stretched level |

## Verification
Assertions watch four properties on every cycle. The output stays quiet after run drops. A restart from idle produces an immediate pulse in pulse mode. A subtract step always lowers the residue. With the configuration held, a stretched output rises only after an add step. The bench's model and window counts cover the properties that need many cycles: the exact count of n enables in every m cycles, the rising-edge count in stretch mode, identical sequences for step values scaled by a power of two, and correct continuation when the configuration changes while running.

// File: rtl/frac_en_div_pkg.sv
package frac_en_div_pkg;

  // Strobes sent from the control module to the datapath
  typedef struct packed {
    logic clear;    // force the residue to zero
    logic advance;  // apply one add-or-subtract step
  } fdivStrobe_t;

  // Status returned by the datapath to the control module
  typedef struct packed {
    logic belowN;     // residue below n: this edge adds and emits an enable
    logic upperHalf;  // twice the updated residue reaches m
  } fdivFlag_t;

endpackage

// File: rtl/frac_en_div_dp.sv
module frac_en_div_dp
  import frac_en_div_pkg::*;
#(
  parameter int FieldW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fdivStrobe_t       strobe,
  input  logic [FieldW-1:0] cfgMadd,
  input  logic [FieldW-1:0] cfgMsub,
  output fdivFlag_t         flags
);

  // One extra bit holds n = 2^W (field 0) and m up to 2^(W+1)-1
  localparam int AccW = FieldW + 1;

  logic [AccW-1:0] acc;
  logic [AccW-1:0] nMag;
  logic [AccW-1:0] mVal;
  logic [AccW-1:0] accAdd;
  logic [AccW-1:0] accSub;
  logic [AccW-1:0] accNext;
  logic            belowN;

  // The stored field carries no sign bit, so its negative value is field - 2^W
  assign nMag    = (AccW'(1) << FieldW) - AccW'(cfgMsub);
  assign mVal    = AccW'(cfgMadd) + nMag;
  assign belowN  = acc < nMag;
  assign accAdd  = acc + AccW'(cfgMadd);
  assign accSub  = acc - nMag;
  assign accNext = belowN ? accAdd : accSub;

  assign flags.belowN    = belowN;
  assign flags.upperHalf = {accNext, 1'b0} >= {1'b0, mVal};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
    end else if (strobe.clear) begin
      acc <= '0;
    end else if (strobe.advance) begin
      acc <= accNext;
    end
  end

  // R3
  sub_descends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.clear && !belowN) |=> (acc < $past(acc)));

endmodule

// File: rtl/frac_en_div_ctrl.sv
module frac_en_div_ctrl
  import frac_en_div_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgRun,
  input  logic        cfgStretch,
  input  fdivFlag_t   flags,
  output fdivStrobe_t strobe,
  output logic        divOut
);

  always_comb begin
    strobe.clear   = !cfgRun;
    strobe.advance = cfgRun;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divOut <= 1'b0;
    end else if (!cfgRun) begin
      divOut <= 1'b0;
    end else if (cfgStretch) begin
      divOut <= flags.upperHalf;
    end else begin
      divOut <= flags.belowN;
    end
  end

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRun |=> !divOut);

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRun && !$past(cfgRun) && !cfgStretch) |=> divOut);

endmodule

// File: rtl/frac_en_div.sv
module frac_en_div
  import frac_en_div_pkg::*;
#(
  parameter int FieldW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FieldW-1:0] cfgMadd,
  input  logic [FieldW-1:0] cfgMsub,
  input  logic              cfgRun,
  input  logic              cfgStretch,
  output logic              divOut
);

  fdivStrobe_t strobe;
  fdivFlag_t   flags;

  frac_en_div_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgRun     (cfgRun),
    .cfgStretch (cfgStretch),
    .flags      (flags),
    .strobe     (strobe),
    .divOut     (divOut)
  );

  frac_en_div_dp #(.FieldW(FieldW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfgMadd (cfgMadd),
    .cfgMsub (cfgMsub),
    .flags   (flags)
  );

  // R7: with the steps and the mode held, a stretched level rises only after an add
  rise_after_add_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(divOut) && $past(cfgStretch) && $past(cfgStretch, 2) &&
     ($past(cfgMadd) == $past(cfgMadd, 2)) && ($past(cfgMsub) == $past(cfgMsub, 2)))
    |-> $past(flags.belowN));

endmodule

// File: tb/tb_frac_en_div.sv
`timescale 1ns/1ps
module tb_frac_en_div;
  localparam int FieldW = 8;
  localparam int Span   = 1 << FieldW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [FieldW-1:0] madd = '0;
  logic [FieldW-1:0] msub = '0;
  logic run = 1'b0;
  logic stretch = 1'b0;
  logic divOut;

  int checks = 0;
  int fails  = 0;
  int mAcc   = 0;
  bit mOut   = 1'b0;
  bit seen   = 1'b0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  frac_en_div #(.FieldW(FieldW)) dut (
    .clk(clk), .rstN(rstN), .cfgMadd(madd), .cfgMsub(msub),
    .cfgRun(run), .cfgStretch(stretch), .divOut(divOut)
  );

  function automatic int nOf(int field);
    return Span - field;
  endfunction

  task automatic expect_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Sample the previous edge's result, then drive the next cycle and update the model
  task automatic tick(int a, int s, bit r, bit st, string req);
    int n, m;
    @(negedge clk);
    seen = divOut;
    expect_eq(req, divOut, mOut);
    madd = FieldW'(a); msub = FieldW'(s); run = r; stretch = st;
    if (!r) begin
      mAcc = 0; mOut = 1'b0;
    end else begin
      n = nOf(s); m = a + n;
      if (mAcc < n) begin mAcc += a; mOut = st ? (2 * mAcc >= m) : 1'b1; end
      else begin mAcc -= n; mOut = st ? (2 * mAcc >= m) : 1'b0; end
    end
  endtask

  task automatic idle(int cycles);
    for (int i = 0; i < cycles; i++) tick(0, 0, 1'b0, 1'b0, "R4");
  endtask

  // Pulse count over m outputs after one warm-up period (R2)
  task automatic count_window(int a, int s, string req);
    int m, cnt;
    m = a + nOf(s);
    idle(2);
    for (int i = 0; i < m + 1; i++) tick(a, s, 1'b1, 1'b0, req);
    cnt = 0;
    for (int i = 0; i < m; i++) begin
      tick(a, s, 1'b1, 1'b0, req);
      cnt += int'(seen);
    end
    expect_eq({req, " window count"}, cnt, nOf(s));
  endtask

  // Rising-edge count over m outputs in stretch mode (R7)
  task automatic count_rises(int a, int s);
    int m, rises;
    bit prev;
    m = a + nOf(s);
    idle(2);
    for (int i = 0; i < m + 1; i++) tick(a, s, 1'b1, 1'b1, "R7");
    prev = seen; rises = 0;
    for (int i = 0; i < m; i++) begin
      tick(a, s, 1'b1, 1'b1, "R7");
      if (seen && !prev) rises++;
      prev = seen;
    end
    expect_eq("R7 rising edges", rises, nOf(s));
  endtask

  initial begin
    #700000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int rv;
    bit streamA[80];
    rv = $urandom(32'd1234);
    #1;
    expect_eq("R1 divOut in reset", divOut, 0);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    idle(3);

    // R1/R5: first running cycle from reset is a pulse
    tick(1, Span - 12, 1'b1, 1'b0, "R5");
    tick(1, Span - 12, 1'b1, 1'b0, "R5");
    expect_eq("R5 first pulse", seen, 1);

    // R2: 12 of 13 and other directed ratios
    count_window(1, Span - 12, "R2");
    count_window(7, Span - 3, "R2");
    count_window(255, 255, "R2");
    // R6: add step zero
    count_window(0, Span - 5, "R6");
    idle(1);
    for (int i = 0; i < 10; i++) tick(0, Span - 5, 1'b1, 1'b0, "R6");
    expect_eq("R6 steady high", seen, 1);
    // R9: subtract field zero means n = 2^W
    count_window(255, 0, "R9");
    count_window(0, 0, "R9");

    // R4: step fields and mode ignored while idle
    for (int i = 0; i < 20; i++)
      tick(int'($urandom_range(255)), int'($urandom_range(255)), 1'b0, 1'(i & 1), "R4");
    tick(3, Span - 2, 1'b1, 1'b0, "R5");
    tick(3, Span - 2, 1'b1, 1'b0, "R5");
    expect_eq("R5 restart pulse", seen, 1);

    // R7: stretch rises with 2n <= m
    count_rises(9, Span - 4);
    count_rises(1, Span - 1);
    count_rises(20, Span - 20);

    // R8: scaled steps give the same stream
    idle(2);
    for (int i = 0; i < 80; i++) begin
      tick(5, Span - 3, 1'b1, 1'b0, "R8");
      streamA[i] = seen;
    end
    idle(2);
    for (int i = 0; i < 80; i++) begin
      tick(5 << 5, Span - (3 << 5), 1'b1, 1'b0, "R8");
      expect_eq("R8 scaled stream", seen, streamA[i]);
    end

    // R10: change steps and mode while running
    idle(2);
    for (int i = 0; i < 15; i++) tick(4, Span - 3, 1'b1, 1'b0, "R10");
    for (int i = 0; i < 15; i++) tick(2, Span - 9, 1'b1, 1'b0, "R10");
    for (int i = 0; i < 15; i++) tick(2, Span - 9, 1'b1, 1'b1, "R10");
    for (int i = 0; i < 15; i++) tick(60, Span - 7, 1'b1, 1'b0, "R10");

    // Random ratios with window counts (R2)
    for (int k = 0; k < 12; k++)
      count_window(int'($urandom_range(255)), int'($urandom_range(255)), "R2");

    // Random per-cycle mixing of all controls (R3)
    for (int i = 0; i < 3000; i++) begin
      int a, s;
      bit r, st;
      a = int'($urandom_range(255)); s = int'($urandom_range(255));
      r = ($urandom_range(9) != 0); st = 1'($urandom_range(1));
      for (int j = 0; j < 5; j++) tick(a, s, r, st, "R3");
    end
    tick(0, 0, 1'b0, 1'b0, "R4");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule